// File: doc/BRIEF.md
# Hashed Key Membership Engine

This block keeps a set of 32-bit keys in an on-chip table of 1024 slots and answers two kinds of command: a lookup, which reports whether a key is in the set, and a store, which adds a key that is not yet present. Each key is placed by open addressing. A hash of the key picks a home slot. When that slot is taken by another key, the search moves to the next slot and wraps past the end of the table. A slot that holds zero is empty, so zero can never be a key.

A filter register collects the OR of every key that has been stored. A lookup for a key that has a bit outside that register cannot match anything in the table. The engine answers it at once and reads no slot. Every other command walks the table one slot per clock. When the walk ends, the engine gives one done pulse that carries the hit flag, the index of the last slot it examined, and the full or error flags. A command is taken through a valid/ready handshake. Only one command is in flight at a time.

Top module: `keyset_probe`

## Requirements
- R1: The home slot of a key is ((key >> 16) XOR key) AND 1023, and the first slot probed is the home slot.
- R2: Each further probe moves to the next slot index modulo 1024, so a probe at slot 1023 is followed by slot 0.
- R3: A probe sequence stops at the first slot that is empty (holds 0) or holds the searched key. After acceptance, done_o rises n+1 clock edges later, where n is the number of slots probed.
- R4: A store writes the key only when probing stops on an empty slot, and then reports hit_o=0. A store of a key already present reports hit_o=1 and leaves the table unchanged.
- R5: A lookup reports hit_o=1 exactly when the slot where probing stopped holds the key. slot_o gives the index of the last slot probed.
- R6: The filter is the OR of all stored keys. A lookup whose key has a bit that is not set in the filter gets done_o one edge after acceptance, with hit_o=0 and slot_o equal to the home slot. Stores bypass this filter.
- R7: A command with key 0 gets done_o one edge after acceptance, with err_o=1, hit_o=0 and slot_o equal to the home slot (0). It does not change the table or the filter.
- R8: If all 1024 slots are probed without a match or an empty slot, the command ends after 1024 probes with hit_o=0 and slot_o one below the home slot modulo 1024. full_o=1 for a store and full_o=0 for a lookup.
- R9: After reset the table and the filter are empty, cmd_ready_o=1 and done_o=0. cmd_ready_o is low from acceptance until done_o has been given. done_o is a one-cycle pulse, and the result flags are valid only while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine idle, command taken when valid |
| cmd_store_i | input | 1 | 1 = store, 0 = lookup |
| cmd_key_i | input | 32 | Key of the command |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Key found in the table |
| full_o | output | 1 | Store found no free slot |
| err_o | output | 1 | Key 0 was rejected |
| slot_o | output | 10 | Index of the last slot probed (home slot on early exit) |

## Verification
Every command is checked against a model table in the bench: result flags, final slot and the exact latency in cycles. A probe that missed the wrap at slot 1023 would report a slot past the end or the wrong slot. A duplicate store that wrote a second copy would show up later as a longer probe chain. The bench builds collision chains that all share home slot 0 and chains that wrap from slot 1023 to slot 0. It also sends keys that the filter should reject, to catch a filter that either probes needlessly or turns away a stored key. In a second run after reset the bench fills all 1024 slots, which checks the full flag for a store, a plain miss for a lookup, and a walk counter that does not stop early or run on forever.

// File: rtl/keyset_pkg.sv
package keyset_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_DONE  = 2'd2
  } state_e;
endpackage

// File: rtl/keyset_hash.sv
module keyset_hash #(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] lo_i,
  input  logic [IDX_W-1:0] hi_i,
  output logic [IDX_W-1:0] idx_o
);
  assign idx_o = lo_i ^ hi_i;
endmodule

// File: rtl/keyset_filter.sv
module keyset_filter #(
  parameter int KEY_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic [KEY_W-1:0] add_key_i,
  input  logic [KEY_W-1:0] chk_key_i,
  output logic             pass_o
);
  logic [KEY_W-1:0] filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    filt_q <= '0;
    else if (add_i) filt_q <= filt_q | add_key_i;
  end

  // key can only be present if all its bits are covered
  assign pass_o = ((filt_q & chk_key_i) == chk_key_i);

  p_filter_grow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q & $past(filt_q)) == $past(filt_q));
endmodule

// File: rtl/keyset_table.sv
module keyset_table #(
  parameter int KEY_W = 32,
  parameter int IDX_W = 10,
  localparam int SLOTS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [KEY_W-1:0] rdata_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [KEY_W-1:0] wdata_i
);
  logic [SLOTS-1:0] occ_q;
  logic [KEY_W-1:0] mem_q [SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   occ_q <= '0;
    else if (we_i) occ_q[waddr_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = occ_q[raddr_i] ? mem_q[raddr_i] : '0;

  p_wr_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (wdata_i != '0));
  p_wr_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !occ_q[waddr_i]);
endmodule

// File: rtl/keyset_probe.sv
module keyset_probe
  import keyset_pkg::*;
#(
  parameter int KEY_W      = 32,
  parameter int IDX_W      = 10,
  parameter int HASH_SHIFT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic             cmd_store_i,
  input  logic [KEY_W-1:0] cmd_key_i,
  output logic             done_o,
  output logic             hit_o,
  output logic             full_o,
  output logic             err_o,
  output logic [IDX_W-1:0] slot_o
);
  localparam logic [IDX_W-1:0] LAST_CNT = '1;

  state_e           state_q;
  logic [KEY_W-1:0] key_q;
  logic             store_q;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] cnt_q;
  logic             hit_q, full_q, err_q;
  logic [IDX_W-1:0] slot_q;

  logic [IDX_W-1:0] home;
  logic [KEY_W-1:0] rd_key;
  logic             filt_pass;
  logic             accept;
  logic             wr_en;
  logic             slot_match, slot_empty;

  keyset_hash #(.IDX_W(IDX_W)) u_hash (
    .lo_i  (cmd_key_i[IDX_W-1:0]),
    .hi_i  (IDX_W'(cmd_key_i >> HASH_SHIFT)),
    .idx_o (home)
  );

  keyset_table #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (ptr_q),
    .rdata_o (rd_key),
    .we_i    (wr_en),
    .waddr_i (ptr_q),
    .wdata_i (key_q)
  );

  keyset_filter #(.KEY_W(KEY_W)) u_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .add_i     (wr_en),
    .add_key_i (key_q),
    .chk_key_i (cmd_key_i),
    .pass_o    (filt_pass)
  );

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign slot_match  = (rd_key == key_q);
  assign slot_empty  = (rd_key == '0);
  assign wr_en       = (state_q == ST_PROBE) && store_q && !slot_match && slot_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      key_q   <= '0;
      store_q <= 1'b0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      hit_q   <= 1'b0;
      full_q  <= 1'b0;
      err_q   <= 1'b0;
      slot_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            key_q   <= cmd_key_i;
            store_q <= cmd_store_i;
            ptr_q   <= home;
            cnt_q   <= '0;
            hit_q   <= 1'b0;
            full_q  <= 1'b0;
            err_q   <= 1'b0;
            slot_q  <= home;
            if (cmd_key_i == '0) begin
              err_q   <= 1'b1;
              state_q <= ST_DONE;
            end else if (!cmd_store_i && !filt_pass) begin
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_PROBE;
            end
          end
        end
        ST_PROBE: begin
          slot_q <= ptr_q;
          if (slot_match) begin
            hit_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (slot_empty) begin
            state_q <= ST_DONE;
          end else if (cnt_q == LAST_CNT) begin
            full_q  <= store_q;
            state_q <= ST_DONE;
          end else begin
            ptr_q <= ptr_q + 1'b1;  // wraps modulo table size
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == ST_DONE);
  assign hit_o  = done_o && hit_q;
  assign full_o = done_o && full_q;
  assign err_o  = done_o && err_q;
  assign slot_o = slot_q;

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_accept_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !cmd_ready_o);
  p_full_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (done_o && !hit_o && !err_o));
  p_err_alone_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!hit_o && !full_o && slot_o == '0));
  p_wr_fresh_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (done_o && !hit_o));
endmodule

// File: tb/sim_keyset_probe.sv
module sim_keyset_probe;
  localparam int SLOTS = 1024;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic        cmd_store_i = 1'b0;
  logic [31:0] cmd_key_i = '0;
  logic        done_o, hit_o, full_o, err_o;
  logic [9:0]  slot_o;

  keyset_probe u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_store_i(cmd_store_i), .cmd_key_i(cmd_key_i),
    .done_o(done_o), .hit_o(hit_o), .full_o(full_o), .err_o(err_o),
    .slot_o(slot_o)
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] m_tab [SLOTS];
  logic [31:0] m_filt;
  logic        g_hit, g_full, g_err;
  logic [9:0]  g_slot;
  int          g_lat;

  task automatic check(input bit ok, input string tag, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog got=%0d exp=<190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    cmd_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < SLOTS; i++) m_tab[i] = '0;
    m_filt = '0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cmd_ready_o && !done_o, "R9 reset idle", {cmd_ready_o, done_o}, 2'b10);
  endtask

  function automatic logic [9:0] home_of(input logic [31:0] k);
    return 10'(((k >> 16) ^ k) & 32'h3FF);
  endfunction

  // one command against the model; tag names the requirement it exercises
  task automatic run(input bit st, input logic [31:0] k, input string tag);
    logic       e_hit, e_full, e_err;
    logic [9:0] e_slot, idx;
    int         e_lat;
    bit         busy_ok;
    e_hit = 0; e_full = 0; e_err = 0;
    e_slot = home_of(k); e_lat = 1;
    if (k == 0) e_err = 1;
    else if (!st && ((m_filt & k) != k)) e_lat = 1;
    else begin
      for (int p = 0; p < SLOTS; p++) begin
        idx = 10'((int'(home_of(k)) + p) % SLOTS);
        e_slot = idx; e_lat = p + 2;
        if (m_tab[idx] == k) begin e_hit = 1; break; end
        if (m_tab[idx] == 0) begin
          if (st) begin m_tab[idx] = k; m_filt |= k; end
          break;
        end
        if (p == SLOTS - 1) e_full = st;
      end
    end
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_store_i = st; cmd_key_i = k;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    g_lat = 1; busy_ok = 1;
    while (!done_o && g_lat < 3000) begin
      if (cmd_ready_o) busy_ok = 0;
      @(negedge clk_i);
      g_lat++;
    end
    if (cmd_ready_o) busy_ok = 0;
    g_hit = hit_o; g_full = full_o; g_err = err_o; g_slot = slot_o;
    check(busy_ok, "R9 ready low while busy", 0, 1);
    check({g_hit, g_full, g_err, g_slot} == {e_hit, e_full, e_err, e_slot} && g_lat == e_lat,
          tag, {g_hit, g_full, g_err, g_slot, 16'(g_lat)}, {e_hit, e_full, e_err, e_slot, 16'(e_lat)});
    @(negedge clk_i);
    check(!done_o, "R9 done single pulse", done_o, 0);
  endtask

  initial begin
    logic [31:0] lf;
    do_reset();
    // empty table: filter rejects everything
    run(0, 32'h5, "R6 reject on empty");
    check(g_lat == 1 && !g_hit, "R6 one-cycle reject", g_lat, 1);
    run(1, 32'h0, "R7 store zero");
    check(g_err && g_slot == 0, "R7 err flag", g_err, 1);
    run(0, 32'h0, "R7 lookup zero");
    run(1, 32'h12345678, "R1 home slot");
    check(g_slot == 10'h04C && g_lat == 2, "R1 slot 0x04C", g_slot, 10'h04C);
    run(0, 32'h12345678, "R5 lookup hit");
    check(g_hit, "R5 hit", g_hit, 1);
    // wrap 1023 -> 0
    run(1, 32'h000003FF, "R1 slot 1023");
    run(1, 32'h000103FE, "R2 wrap store");
    check(g_slot == 0 && g_lat == 3, "R2 wrapped to 0", g_slot, 0);
    // chain on home slot 0 (now occupied)
    for (int i = 1; i <= 6; i++) run(1, (32'(2*i+1) << 16) | 32'(2*i+1), "R3 chain store");
    check(g_slot == 6 && g_lat == 8, "R3 chain length", g_lat, 8);
    run(1, 32'h00050005, "R4 duplicate store");
    check(g_hit && g_slot == 2, "R4 dup hit", g_slot, 2);
    run(0, 32'h00070007, "R5 mid-chain hit");
    run(0, 32'h00010001, "R3 miss ends at empty");
    check(!g_hit && g_slot == 7, "R3 stop at empty", g_slot, 7);
    run(0, 32'h80000000, "R6 filter reject");
    check(g_lat == 1, "R6 no probe", g_lat, 1);
    // mixed sweep with heavy collisions
    lf = 32'hACE1_2357;
    for (int i = 0; i < 400; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      run(lf[0], lf & 32'h00FF_00FF, lf[0] ? "R4 sweep store" : "R5 sweep lookup");
      if (i % 4 == 0) run(0, lf, "R6 sweep lookup");
    end
    // second run: fill the whole table
    do_reset();
    run(0, 32'h12345678, "R9 table cleared");
    for (int i = 1; i <= SLOTS; i++) run(1, 32'(i), "R1 fill");
    run(1, 32'd1025, "R8 store into full");
    check(g_full && g_slot == 0 && g_lat == SLOTS + 1, "R8 full flag", {g_full, g_slot}, 11'h400);
    run(0, 32'd1025, "R8 lookup in full");
    check(!g_full && !g_hit, "R8 lookup no full", g_full, 0);
    run(0, 32'd700, "R5 hit in full table");
    run(0, 32'd2048, "R6 reject in full table");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule